// File: doc/BRIEF.md
# Legacy Interrupt Cause Register with Auxiliary Notification Bit

This block holds the cause of a level-triggered interrupt for a paravirtual PCI device that is running without message-signalled interrupts. Three event sources each own one sticky bit:

- queue activity sets bit 0;
- a device configuration change sets bit 1;
- the single auxiliary driver notification sets bit 2.

The legacy mode can carry only one auxiliary notification. Without per-event vectors the driver has no way to tell several auxiliary sources apart.

The driver pulses a read strobe. The block then returns the 32-bit cause word on the cycle after the strobe and clears every cause bit at the same edge. An event that arrives on the read cycle is not lost: it stays stored for the next read. A registered level interrupt line is high whenever any cause bit is stored.

When the vectored interrupt mode is switched on, this register no longer reports anything. Events are ignored, stored bits are dropped, reads return zero and the line stays low.

Top module: `irq_cause_reg`

## Requirements
- R1: A one-cycle pulse on `queue_evt` sets cause bit 0, which stays set until a read or reset.
- R2: A one-cycle pulse on `cfg_evt` sets cause bit 1, which stays set until a read or reset.
- R3: A one-cycle pulse on `aux_evt` sets cause bit 2, which stays set until a read or reset.
- R4: Bits 31 down to 3 of `rd_data` are always zero.
- R5: A cycle with `rd_req` high has the following effect at the next edge. `rd_data` is loaded with the cause bits stored before that edge, and all those stored bits are cleared.
- R6: An event pulse in the same cycle as `rd_req` does not appear in that read. It is stored and reported by the following read.
- R7: After every clock edge, `irq_level` is 1 exactly when at least one cause bit is stored.
- R8: While `vec_mode_en` is high, events do not set bits and stored bits are cleared. A read loads zero into `rd_data`, and `irq_level` goes low at the next edge.
- R9: Synchronous active-high `rst` clears all cause bits, `rd_data` and `irq_level`.
- R10: `rd_data` keeps its value in cycles without `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode_en | input | 1 | Vectored interrupt mode enabled; suppresses status reporting |
| queue_evt | input | 1 | Queue event pulse (cause bit 0) |
| cfg_evt | input | 1 | Configuration change event pulse (cause bit 1) |
| aux_evt | input | 1 | Auxiliary driver notification pulse (cause bit 2) |
| rd_req | input | 1 | Driver read strobe; read-and-clear |
| rd_data | output | 32 | Registered cause word from the last read |
| irq_level | output | 1 | Registered legacy level interrupt |

## Verification
Two functions can fall in the same cycle: a new event pulse and the driver's read-and-clear. The sticky bit must then be cleared and set again at once. The bench provokes this by pulsing one or more events in the very cycle of a read strobe, including the case where the same cause is already stored. It then checks two things. The read returns only the causes stored before that edge. A second read returns the cause that arrived during the first one, and `irq_level` stays high in between. The reference model also covers an event that coincides with vectored mode being switched on, where the event must vanish.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int CAUSE_Q   = 0;
  localparam int CAUSE_CFG = 1;
  localparam int CAUSE_AUX = 2;
  localparam int NUM_CAUSE = 3;
endpackage

// File: rtl/irq_cause_bit.sv
// One sticky cause bit: set by a pulse, cleared by a read, dropped while blanked.
module irq_cause_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic blank_i,
  output logic nxt_o,
  output logic q_o
);
  always_comb begin
    if (blank_i) nxt_o = 1'b0;
    else         nxt_o = (q_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/irq_cause_readport.sv
// Registered read data: snapshot of the stored causes, zero-extended.
module irq_cause_readport #(
  parameter int DATA_W    = 32,
  parameter int NUM_CAUSE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_i,
  input  logic                 blank_i,
  input  logic [NUM_CAUSE-1:0] cause_i,
  output logic [DATA_W-1:0]    data_o
);
  localparam int PAD_W = DATA_W - NUM_CAUSE;

  logic [DATA_W-1:0] word;
  assign word = blank_i ? '0 : {{PAD_W{1'b0}}, cause_i};

  always_ff @(posedge clk) begin
    if (rst)       data_o <= '0;
    else if (rd_i) data_o <= word;
  end
endmodule

// File: rtl/irq_cause_line.sv
// Registered level interrupt from the next-state cause vector.
module irq_cause_line #(
  parameter int NUM_CAUSE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CAUSE-1:0] nxt_i,
  output logic                 irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |nxt_i;
  end
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vec_mode_en,
  input  logic              queue_evt,
  input  logic              cfg_evt,
  input  logic              aux_evt,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_level
);
  logic [NUM_CAUSE-1:0] evt_vec;
  logic [NUM_CAUSE-1:0] cause_q;
  logic [NUM_CAUSE-1:0] cause_nxt;

  always_comb begin
    evt_vec            = '0;
    evt_vec[CAUSE_Q]   = queue_evt;
    evt_vec[CAUSE_CFG] = cfg_evt;
    evt_vec[CAUSE_AUX] = aux_evt;
  end

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    irq_cause_bit u_bit (
      .clk     (clk),
      .rst     (rst),
      .set_i   (evt_vec[g]),
      .clr_i   (rd_req),
      .blank_i (vec_mode_en),
      .nxt_o   (cause_nxt[g]),
      .q_o     (cause_q[g])
    );
  end

  irq_cause_readport #(.DATA_W(DATA_W), .NUM_CAUSE(NUM_CAUSE)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_req),
    .blank_i (vec_mode_en),
    .cause_i (cause_q),
    .data_o  (rd_data)
  );

  irq_cause_line #(.NUM_CAUSE(NUM_CAUSE)) u_line (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (cause_nxt),
    .irq_o (irq_level)
  );
endmodule

// File: rtl/irq_cause_reg_chk.sv
module irq_cause_reg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              vec_mode_en,
  input logic              queue_evt,
  input logic              cfg_evt,
  input logic              aux_evt,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_level
);
  // R4
  p_rsv_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:3] == '0);
  // R1 with R7
  p_queue_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (queue_evt && !vec_mode_en) |=> irq_level);
  // R2 with R7
  p_cfg_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_evt && !vec_mode_en) |=> irq_level);
  // R3 with R7
  p_aux_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (aux_evt && !vec_mode_en) |=> irq_level);
  // R5: read with no new event leaves nothing stored
  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !queue_evt && !cfg_evt && !aux_evt) |=> !irq_level);
  // R8
  p_vec_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    vec_mode_en |=> (!irq_level));
  p_vec_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (vec_mode_en && rd_req) |=> (rd_data == '0));
  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));
endmodule

bind irq_cause_reg irq_cause_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .vec_mode_en (vec_mode_en),
  .queue_evt   (queue_evt),
  .cfg_evt     (cfg_evt),
  .aux_evt     (aux_evt),
  .rd_req      (rd_req),
  .rd_data     (rd_data),
  .irq_level   (irq_level)
);

// File: tb/irq_cause_reg_tb_top.sv
`timescale 1ns/1ps
module irq_cause_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vec_mode_en = 1'b0;
  logic        queue_evt = 1'b0;
  logic        cfg_evt = 1'b0;
  logic        aux_evt = 1'b0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_data;
  logic        irq_level;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_q, m_c, m_a;
  int m_rd;
  int m_irq;

  always #10 clk = ~clk;

  irq_cause_reg dut_i (
    .clk(clk), .rst(rst), .vec_mode_en(vec_mode_en),
    .queue_evt(queue_evt), .cfg_evt(cfg_evt), .aux_evt(aux_evt),
    .rd_req(rd_req), .rd_data(rd_data), .irq_level(irq_level)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus, advance model, compare after the edge
  task automatic cyc(input bit r, input bit q, input bit c, input bit a,
                     input bit rd, input bit vec, input string tag);
    int evq, evc, eva;
    rst = r; queue_evt = q; cfg_evt = c; aux_evt = a;
    rd_req = rd; vec_mode_en = vec;
    @(posedge clk);
    if (r) begin
      m_q = 0; m_c = 0; m_a = 0; m_rd = 0;
    end else if (vec) begin
      if (rd) m_rd = 0;
      m_q = 0; m_c = 0; m_a = 0;
    end else begin
      if (rd) begin
        m_rd = m_q + 2*m_c + 4*m_a;
        m_q = 0; m_c = 0; m_a = 0;
      end
      evq = q; evc = c; eva = a;
      if (evq != 0) m_q = 1;
      if (evc != 0) m_c = 1;
      if (eva != 0) m_a = 1;
    end
    m_irq = (m_q + m_c + m_a) > 0 ? 1 : 0;
    @(negedge clk);
    chk({tag, " rd_data"}, int'(rd_data), m_rd);
    chk({tag, " irq_level"}, int'(irq_level), m_irq);
    chk({tag, " R4 reserved"}, int'(rd_data[31:3]), 0);
  endtask

  initial begin
    m_q = 0; m_c = 0; m_a = 0; m_rd = 0; m_irq = 0;
    @(negedge clk);
    cyc(1,0,0,0,0,0,"R9 reset");
    cyc(1,0,0,0,0,0,"R9 reset");
    cyc(0,0,0,0,0,0,"R9 idle");
    // R1 queue bit
    cyc(0,1,0,0,0,0,"R1 queue set");
    cyc(0,0,0,0,0,0,"R1 sticky");
    cyc(0,0,0,0,1,0,"R5 read q");
    chk("R1 read value", int'(rd_data), 1);
    cyc(0,0,0,0,0,0,"R10 hold");
    // R2 config bit
    cyc(0,0,1,0,0,0,"R2 cfg set");
    cyc(0,0,0,0,1,0,"R5 read cfg");
    chk("R2 read value", int'(rd_data), 2);
    // R3 aux bit
    cyc(0,0,0,1,0,0,"R3 aux set");
    cyc(0,0,0,1,0,0,"R3 aux again");
    cyc(0,0,0,0,1,0,"R5 read aux");
    chk("R3 read value", int'(rd_data), 4);
    // all three, R7
    cyc(0,1,0,0,0,0,"R7 q");
    cyc(0,0,1,1,0,0,"R7 cfg+aux");
    cyc(0,0,0,0,1,0,"R5 read all");
    chk("R5 read all value", int'(rd_data), 7);
    chk("R7 line low after read", int'(irq_level), 0);
    // R6 event during read
    cyc(0,1,0,0,0,0,"R6 prep");
    cyc(0,0,0,1,1,0,"R6 aux with read");
    chk("R6 first read", int'(rd_data), 1);
    chk("R6 line kept", int'(irq_level), 1);
    cyc(0,0,0,0,0,0,"R10 hold2");
    cyc(0,0,0,0,1,0,"R6 second read");
    chk("R6 second read value", int'(rd_data), 4);
    // R6 same cause already set and re-pulsed on read
    cyc(0,0,1,0,0,0,"R6 cfg set");
    cyc(0,0,1,0,1,0,"R6 cfg with read");
    cyc(0,0,0,0,1,0,"R6 cfg reread");
    chk("R6 cfg reread value", int'(rd_data), 2);
    cyc(0,0,0,0,1,0,"R5 empty read");
    // R8 vectored mode
    cyc(0,1,0,1,0,0,"R8 prep");
    cyc(0,0,1,0,0,1,"R8 vec on with cfg");
    chk("R8 line low", int'(irq_level), 0);
    cyc(0,1,1,1,0,1,"R8 events ignored");
    cyc(0,0,0,0,1,1,"R8 vec read");
    chk("R8 read zero", int'(rd_data), 0);
    cyc(0,0,0,0,0,0,"R8 vec off");
    cyc(0,0,0,0,1,0,"R8 nothing kept");
    chk("R8 nothing kept value", int'(rd_data), 0);
    cyc(0,0,0,1,0,0,"R8 aux after vec");
    cyc(0,0,0,0,1,0,"R8 read aux");
    // R9 reset with state
    cyc(0,1,1,0,0,0,"R9 prep");
    cyc(1,0,0,0,0,0,"R9 reset with bits");
    chk("R9 line", int'(irq_level), 0);
    chk("R9 rd_data", int'(rd_data), 0);
    cyc(0,0,0,0,1,0,"R9 read after reset");
    // R10 hold sequence
    cyc(0,1,0,1,0,0,"R10 prep");
    cyc(0,0,0,0,1,0,"R10 read");
    for (int i = 0; i < 4; i++) cyc(0,(i==1),0,0,0,0,"R10 holding");
    chk("R10 held value", int'(rd_data), 5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule